// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches. It keeps one shift register holding the outcomes of the most recent resolved branches, whichever branches they were. Those outcomes choose one of several pattern tables, and the low bits of the branch address choose a row within that table. Each row holds a small saturating counter, and the top bit of the counter is the prediction.

A fetch stage presents a branch address on the lookup port and reads back taken or not taken in the same cycle. When the branch resolves, the pipeline presents the branch address and the real outcome on the update port. The update first trains the counter selected by the current history. The outcome is then shifted into the history.

The history length, the address index width and the counter width are parameters. When the history length is zero, the block becomes a single table indexed by address alone.

Top module: `corr_branch_pred`

## Requirements
- R1: Each accepted update shifts the resolved outcome into the history register at bit 0, and the older bits move up one place. Without an update, the history keeps its value.
- R2: The counter used is the one at index {history, pc[IDX_W-1:0]}. Addresses that differ only above bit IDX_W-1 share that counter.
- R3: A taken update adds one to the addressed counter. A counter already at its maximum (3 for 2 bits) stays there.
- R4: A not-taken update subtracts one from the addressed counter. A counter already at 0 stays at 0.
- R5: The lookup output equals the most significant bit of the addressed counter: 1 means taken and 0 means not taken.
- R6: Reset clears the history to 0 and sets every counter to weakly not-taken (01 for 2 bits). After reset, every lookup predicts not taken.
- R7: An update trains the counter indexed by the history value from before that update's own outcome is shifted in.
- R8: When a lookup and an update address the same counter in the same cycle, the lookup returns the counter value from before the update.
- R9: In a cycle without an update, no counter and no history bit changes, so the prediction for a fixed address stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | Branch address to predict |
| lkp_taken_o | output | 1 | Prediction: 1 taken, 0 not taken |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome: 1 taken |

## Verification
The bench drives runs of taken outcomes long enough to pin the history at all ones. This repeatedly trains a single counter up to its ceiling and then steps it back. A counter that wraps would flip the prediction to not taken at that point. Runs of not-taken outcomes do the same at the floor, where a wrapping counter would jump to strongly taken.

Same-cycle lookup and update of one entry catches a write-through design, which would show the trained value one cycle early. Lookups at addresses that differ only in high bits catch an index built from the wrong address bits. Random traffic, compared against a reference model, exposes an update that uses the history after the shift, because the model trains a different table in that case.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
  // saturating up/down step for a counter of w bits (w <= 8)
  function automatic logic [7:0] sat_step(logic [7:0] cur, logic up, int unsigned w);
    logic [7:0] top;
    top = 8'((9'd1 << w) - 9'd1);
    if (up) return (cur == top) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

  function automatic logic [7:0] weak_nt(int unsigned w);
    return 8'((9'd1 << (w - 1)) - 9'd1);
  endfunction
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned HIST_W = 2,
  localparam int unsigned HW = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [HW-1:0] hist_o
);
  if (HIST_W > 0) begin : g_hist
    logic [HW-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= '0;
      else if (shift_i) hist_q <= (hist_q << 1) | HW'(bit_i);
    end
    assign hist_o = hist_q;
  end else begin : g_none
    logic unused;
    assign unused = clk_i ^ rst_ni ^ shift_i ^ bit_i;
    assign hist_o = '0;
  end
endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table
  import corr_bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CTR_W-1:0]  rd_ctr_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_taken_i
);
  localparam logic [CTR_W-1:0] INIT = CTR_W'(weak_nt(CTR_W));

  logic [CTR_W-1:0] ctr_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctr_q[i] <= INIT;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(i)))
        ctr_q[i] <= CTR_W'(sat_step(8'(ctr_q[i]), wr_taken_i, CTR_W));
    end
  end

  assign rd_ctr_o = ctr_q[rd_addr_i];
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CTR_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            lkp_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned HW     = (HIST_W > 0) ? HIST_W : 1;
  localparam int unsigned ADDR_W = HIST_W + IDX_W;

  logic [HW-1:0]     hist;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [CTR_W-1:0]  rd_ctr;

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist)
  );

  // update indexes with pre-shift history; shift lands at the same edge
  if (HIST_W > 0) begin : g_idx_hist
    assign rd_addr = {hist, lkp_pc_i[IDX_W-1:0]};
    assign wr_addr = {hist, upd_pc_i[IDX_W-1:0]};
  end else begin : g_idx_pc
    assign rd_addr = lkp_pc_i[IDX_W-1:0];
    assign wr_addr = upd_pc_i[IDX_W-1:0];
  end

  bp_pattern_table #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_ctr_o  (rd_ctr),
    .wr_en_i   (upd_valid_i),
    .wr_addr_i (wr_addr),
    .wr_taken_i(upd_taken_i)
  );

  assign lkp_taken_o = rd_ctr[CTR_W-1];
endmodule

// File: rtl/corr_bp_checker.sv
module corr_bp_checker #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 2,
  localparam int unsigned HW = (HIST_W > 0) ? HIST_W : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lkp_pc_i,
  input logic            lkp_taken_o,
  input logic            upd_valid_i,
  input logic            upd_taken_i,
  input logic [HW-1:0]   hist_i
);
  // R1
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_i == ((HIST_W > 0) ? HW'(($past(hist_i) << 1) | HW'($past(upd_taken_i))) : HW'(0)));

  // R1
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_i));

  // R6
  hist_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> hist_i == '0);

  // R9
  pred_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(upd_valid_i) && $stable(lkp_pc_i)) |-> $stable(lkp_taken_o));
endmodule

bind corr_branch_pred corr_bp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lkp_pc_i   (lkp_pc_i),
  .lkp_taken_o(lkp_taken_o),
  .upd_valid_i(upd_valid_i),
  .upd_taken_i(upd_taken_i),
  .hist_i     (hist)
);

// File: tb/tb_corr_branch_pred.sv
module tb_corr_branch_pred;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int HIST_W = 2;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << (HIST_W + IDX_W);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [PC_W-1:0] lkp_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic lkp_taken;

  int n_tests = 0, n_fail = 0;
  int ref_ctr [DEPTH];
  int ref_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_branch_pred #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .CTR_W(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc), .lkp_taken_o(lkp_taken),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken)
  );

  function automatic int ref_idx(logic [PC_W-1:0] pc);
    return (ref_hist << IDX_W) | int'(pc[IDX_W-1:0]);
  endfunction

  function automatic logic ref_pred(logic [PC_W-1:0] pc);
    return ref_ctr[ref_idx(pc)] >= 2;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, lkp_pc, act, exp);
    end
  endtask

  // drive one cycle, check lookup before the edge, then advance the model
  task automatic step(logic [PC_W-1:0] lpc, logic v, logic [PC_W-1:0] upc, logic t, string tag);
    int i;
    @(negedge clk);
    lkp_pc = lpc; upd_valid = v; upd_pc = upc; upd_taken = t;
    #1 check(tag, lkp_taken, ref_pred(lpc));
    @(posedge clk);
    if (v) begin
      i = ref_idx(upc);
      if (t) ref_ctr[i] = (ref_ctr[i] == 3) ? 3 : ref_ctr[i] + 1;
      else   ref_ctr[i] = (ref_ctr[i] == 0) ? 0 : ref_ctr[i] - 1;
      ref_hist = ((ref_hist << 1) | int'(t)) & ((1 << HIST_W) - 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F2E;
    void'($urandom(seed));
    ref_hist = 0;
    for (int i = 0; i < DEPTH; i++) ref_ctr[i] = 1;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_ni = 1'b1;

    // R6: all addresses not taken after reset
    for (int p = 0; p < 16; p++) step(PC_W'(p), 1'b0, '0, 1'b0, "R6");

    // R8: same entry read while trained, then R7 the trained table is hist 00
    step(32'h5, 1'b1, 32'h5, 1'b1, "R8");
    step(32'h5, 1'b0, '0, 1'b0, "R7");
    // R3: taken run pins history at all ones and saturates one entry
    for (int k = 0; k < 6; k++) step(32'h5, 1'b1, 32'h5, 1'b1, "R3");
    step(32'h5, 1'b1, 32'h5, 1'b0, "R3");
    step(32'h5, 1'b0, '0, 1'b0, "R3");
    // R2: high address bits are ignored
    step(32'hABCD_0105, 1'b0, '0, 1'b0, "R2");
    step(32'h0000_0F05, 1'b0, '0, 1'b0, "R2");
    // R4: not-taken run saturates at zero, then one taken step
    for (int k = 0; k < 6; k++) step(32'h9, 1'b1, 32'h9, 1'b0, "R4");
    step(32'h9, 1'b1, 32'h9, 1'b1, "R4");
    step(32'h9, 1'b0, '0, 1'b0, "R4");
    // R9: idle cycles keep prediction
    for (int k = 0; k < 4; k++) step(32'h5, 1'b0, 32'h5, 1'b1, "R9");

    // R1/R5: random traffic against model
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] a, b;
      logic bias;
      a = PC_W'($urandom() & 32'hFFF);
      b = ($urandom() % 3 == 0) ? a : PC_W'($urandom() & 32'hFFF);
      bias = ($urandom() % 4) != 0;
      step(a, ($urandom() % 5) != 0, b, bias ^ b[0], "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule